// File: doc/BRIEF.md
# Error Transaction-ID Capture Registers

This block keeps the transaction identifier of the first failing transfer in each of three error classes. The classes are correctable single-bit memory errors, uncorrectable double-bit memory errors, and data-bus errors. Data-bus errors are errors on the processor bus or on the internal data path that carry no memory-ECC flag. Every retire command from the transaction tracker carries a 6-bit identifier and three flags. When a command falls in a class whose register is empty and not disabled, the block stores the identifier. It then asserts a per-class hold output with the stored identifier, so the tracker does not reissue that identifier until software releases it.

Software reaches the three 8-bit registers through a byte-wide read/write port with an 8-bit offset. Each register holds a disable bit, a valid flag and the stored identifier. Software releases an identifier by writing 1 to the valid bit. The stored contents are sticky: only the power-on reset clears them, and the warm reset clears only the read-data register.

Top module: `errid_capture`

## Requirements
- R1: While `por_rst` is high at a clock edge, all three registers become 00h, `hold_vld` becomes 000b, `hold_id` becomes all zero and `rd_data` becomes 00h after that edge.
- R2: The single-bit register sits at offset 80h, the double-bit register at 81h and the bus-error register at 82h. In each register bit 7 is the disable bit, bit 6 is the valid flag and bits 5:0 are the identifier. A read with `rd_en` high returns the addressed register on `rd_data` after the next edge, showing the state from before that edge. Any other offset reads 00h, and `rd_data` is 00h after an edge without `rd_en`.
- R3: A retire command with `ret_ded` high belongs to the double-bit class, whatever the other two flags are.
- R4: A retire command with `ret_sec` high and `ret_ded` low belongs to the single-bit class.
- R5: A retire command belongs to the bus-error class only when `ret_ade` is high and both `ret_sec` and `ret_ded` are low. A command with none of the three flags belongs to no class.
- R6: When a class register is already valid, a further command of that class leaves the stored identifier unchanged.
- R7: When a class's disable bit is 1 before the edge, a command of that class is not captured. A write sets or clears the disable bit from `wr_data` bit 7.
- R8: A write with `wr_data` bit 6 set clears the valid flag and the identifier of the addressed register. A write with bit 6 clear leaves them unchanged. Writes to bits 5:0 are always ignored.
- R9: `hold_vld[k]` equals the valid flag of class k (0 single-bit, 1 double-bit, 2 bus-error), and `hold_id[k]` equals its stored identifier. Both drop in the cycle after the clearing write.
- R10: When a clearing write and a capturing command reach the same register at the same edge, the clear takes effect first and the new identifier is stored with the valid flag set.
- R11: `warm_rst` changes no register contents and no hold output. It forces `rd_data` to 00h after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset, synchronous, active high, clears read data only |
| ret_vld | input | 1 | Retire command strobe |
| ret_id | input | 6 | Identifier being retired |
| ret_sec | input | 1 | Correctable single-bit error flag |
| ret_ded | input | 1 | Uncorrectable double-bit error flag |
| ret_ade | input | 1 | Data-bus error flag |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_off | input | 8 | Register byte offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after `rd_en` |
| hold_vld | output | 3 | Per-class hold indication |
| hold_id | output | 18 | Per-class held identifier, 6 bits per class |

## Verification
A wrong valid flag or identifier shows on `hold_vld` and `hold_id` in the cycle right after the edge that corrupted it. It also shows on `rd_data` one cycle after a read of that offset. A wrong decode of the class flags or a wrong clear/capture order therefore appears within one or two cycles. Reset stickiness is checked by comparing the hold outputs across a warm reset with the outputs before it. A behavioural model in the bench predicts every output on every cycle, for directed and random command and register traffic.

// File: rtl/errid_pkg.sv
package errid_pkg;

    localparam int ID_W      = 6;
    localparam int NUM_CLS   = 3;
    localparam int REG_W     = 8;
    localparam int OFF_W     = 8;
    localparam int DIS_BIT   = 7;
    localparam int VLD_BIT   = 6;
    localparam logic [OFF_W-1:0] BASE_OFF = 8'h80;

    typedef enum logic [1:0] {
        CLS_SEC = 2'd0,
        CLS_DED = 2'd1,
        CLS_BUS = 2'd2
    } err_cls_e;

    typedef struct packed {
        logic            dis;
        logic            vld;
        logic [ID_W-1:0] id;
    } slot_reg_t;

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
        logic            sec;
        logic            ded;
        logic            ade;
    } retire_t;

    // Double-bit outranks single-bit; bus error only when no memory flag.
    function automatic logic [NUM_CLS-1:0] classify(input logic sec,
                                                    input logic ded,
                                                    input logic ade);
        logic [NUM_CLS-1:0] r;
        r = '0;
        r[CLS_DED] = ded;
        r[CLS_SEC] = sec & ~ded;
        r[CLS_BUS] = ade & ~sec & ~ded;
        return r;
    endfunction

endpackage

// File: rtl/errid_classify.sv
module errid_classify
    import errid_pkg::*;
(
    input  retire_t            cmd,
    output logic [NUM_CLS-1:0] hit
);
    logic [NUM_CLS-1:0] cls;

    always_comb begin
        cls = classify(cmd.sec, cmd.ded, cmd.ade);
        hit = cmd.vld ? cls : '0;
    end
endmodule

// File: rtl/errid_slot.sv
module errid_slot
    import errid_pkg::*;
#(
    parameter logic [OFF_W-1:0] SLOT_OFF = 8'h80
) (
    input  logic             clk,
    input  logic             por_rst,
    input  logic             hit,
    input  logic [ID_W-1:0]  cap_id,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [REG_W-1:0] wr_data,
    output slot_reg_t        q
);
    logic      sel;
    logic      clr;
    slot_reg_t after_clr;
    slot_reg_t nxt;

    always_comb begin
        sel = wr_en && (wr_off == SLOT_OFF);
        clr = sel && wr_data[VLD_BIT];

        after_clr     = q;
        after_clr.dis = sel ? wr_data[DIS_BIT] : q.dis;
        if (clr) begin
            after_clr.vld = 1'b0;
            after_clr.id  = '0;
        end

        nxt = after_clr;
        // disable is judged on its value held before this edge
        if (hit && !q.dis && !after_clr.vld) begin
            nxt.vld = 1'b1;
            nxt.id  = cap_id;
        end
    end

    always_ff @(posedge clk) begin
        if (por_rst) q <= '0;
        else         q <= nxt;
    end
endmodule

// File: rtl/errid_rdport.sv
module errid_rdport
    import errid_pkg::*;
(
    input  logic                      clk,
    input  logic                      por_rst,
    input  logic                      warm_rst,
    input  logic                      rd_en,
    input  logic [OFF_W-1:0]          rd_off,
    input  slot_reg_t [NUM_CLS-1:0]   slots,
    output logic [REG_W-1:0]          rd_data
);
    logic [REG_W-1:0] sel_val;

    always_comb begin
        sel_val = '0;
        for (int k = 0; k < NUM_CLS; k++) begin
            if (rd_off == BASE_OFF + OFF_W'(k)) sel_val = slots[k];
        end
    end

    always_ff @(posedge clk) begin
        if (por_rst || warm_rst) rd_data <= '0;
        else if (rd_en)          rd_data <= sel_val;
        else                     rd_data <= '0;
    end
endmodule

// File: rtl/errid_capture.sv
module errid_capture
    import errid_pkg::*;
(
    input  logic                           clk,
    input  logic                           por_rst,
    input  logic                           warm_rst,
    input  logic                           ret_vld,
    input  logic [ID_W-1:0]                ret_id,
    input  logic                           ret_sec,
    input  logic                           ret_ded,
    input  logic                           ret_ade,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [OFF_W-1:0]               reg_off,
    input  logic [REG_W-1:0]               wr_data,
    output logic [REG_W-1:0]               rd_data,
    output logic [NUM_CLS-1:0]             hold_vld,
    output logic [NUM_CLS-1:0][ID_W-1:0]   hold_id
);
    retire_t                  cmd;
    logic [NUM_CLS-1:0]       hit;
    slot_reg_t [NUM_CLS-1:0]  slots;
    logic [NUM_CLS-1:0]       dis_vec;

    assign cmd = '{vld: ret_vld, id: ret_id, sec: ret_sec, ded: ret_ded, ade: ret_ade};

    errid_classify u_cls (
        .cmd (cmd),
        .hit (hit)
    );

    for (genvar k = 0; k < NUM_CLS; k++) begin : g_slot
        errid_slot #(
            .SLOT_OFF (BASE_OFF + OFF_W'(k))
        ) u_slot (
            .clk     (clk),
            .por_rst (por_rst),
            .hit     (hit[k]),
            .cap_id  (cmd.id),
            .wr_en   (wr_en),
            .wr_off  (reg_off),
            .wr_data (wr_data),
            .q       (slots[k])
        );
        assign hold_vld[k] = slots[k].vld;
        assign hold_id[k]  = slots[k].id;
        assign dis_vec[k]  = slots[k].dis;
    end

    errid_rdport u_rd (
        .clk      (clk),
        .por_rst  (por_rst),
        .warm_rst (warm_rst),
        .rd_en    (rd_en),
        .rd_off   (reg_off),
        .slots    (slots),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/errid_capture_chk.sv
module errid_capture_chk
    import errid_pkg::*;
(
    input logic                         clk,
    input logic                         por_rst,
    input logic                         warm_rst,
    input logic                         ret_vld,
    input logic                         ret_sec,
    input logic                         ret_ded,
    input logic                         ret_ade,
    input logic                         wr_en,
    input logic                         rd_en,
    input logic [OFF_W-1:0]             reg_off,
    input logic [REG_W-1:0]             wr_data,
    input logic [REG_W-1:0]             rd_data,
    input logic [NUM_CLS-1:0]           hold_vld,
    input logic [NUM_CLS-1:0][ID_W-1:0] hold_id,
    input logic [NUM_CLS-1:0]           dis_vec
);
    logic [NUM_CLS-1:0] cls_now;
    logic               unmapped;
    assign cls_now  = {ret_ade & ~ret_sec & ~ret_ded, ret_ded, ret_sec & ~ret_ded};
    assign unmapped = (reg_off < BASE_OFF) || (reg_off >= BASE_OFF + OFF_W'(NUM_CLS));

    // R1: power-on reset empties everything
    assert_por_clear_R1: assert property (@(posedge clk)
        por_rst |=> (hold_vld == '0 && rd_data == '0));

    // R2: unmapped offsets read as zero
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (por_rst)
        (rd_en && unmapped && !warm_rst) |=> rd_data == '0);

    // R11: warm reset leaves sticky state alone
    assert_warm_sticky_R11: assert property (@(posedge clk) disable iff (por_rst)
        (warm_rst && !ret_vld && !wr_en) |=> ($stable(hold_vld) && $stable(hold_id)));

    for (genvar k = 0; k < NUM_CLS; k++) begin : g_chk
        logic sel_k;
        assign sel_k = wr_en && (reg_off == BASE_OFF + OFF_W'(k));

        // R6: a valid slot keeps its identifier unless cleared
        assert_first_kept_R6: assert property (@(posedge clk) disable iff (por_rst)
            (hold_vld[k] && !(sel_k && wr_data[VLD_BIT])) |=> $stable(hold_id[k]));

        // R7: a disabled empty slot stays empty
        assert_disabled_no_cap_R7: assert property (@(posedge clk) disable iff (por_rst)
            (!hold_vld[k] && dis_vec[k]) |=> !hold_vld[k]);

        // R8/R9: clear without a competing capture drops the hold next cycle
        assert_w1c_drop_R9: assert property (@(posedge clk) disable iff (por_rst)
            (sel_k && wr_data[VLD_BIT] && !(ret_vld && cls_now[k])) |=> !hold_vld[k]);

        // R10: clear plus capture on an enabled slot leaves it valid
        assert_clear_then_cap_R10: assert property (@(posedge clk) disable iff (por_rst)
            (sel_k && wr_data[VLD_BIT] && ret_vld && cls_now[k] && !dis_vec[k]) |=> hold_vld[k]);
    end
endmodule

bind errid_capture errid_capture_chk u_chk (
    .clk      (clk),
    .por_rst  (por_rst),
    .warm_rst (warm_rst),
    .ret_vld  (ret_vld),
    .ret_sec  (ret_sec),
    .ret_ded  (ret_ded),
    .ret_ade  (ret_ade),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .reg_off  (reg_off),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .hold_vld (hold_vld),
    .hold_id  (hold_id),
    .dis_vec  (dis_vec)
);

// File: tb/sim_errid_capture.sv
module sim_errid_capture;
    logic              clk = 1'b0;
    logic              por_rst = 1'b1, warm_rst = 1'b0;
    logic              ret_vld = 1'b0, ret_sec = 1'b0, ret_ded = 1'b0, ret_ade = 1'b0;
    logic [5:0]        ret_id = '0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]        reg_off = '0, wr_data = '0;
    logic [7:0]        rd_data;
    logic [2:0]        hold_vld;
    logic [2:0][5:0]   hold_id;

    always #4 clk = ~clk;   // 125 MHz

    errid_capture u0 (.*);

    // behavioural reference
    int  m_dis[3], m_val[3], m_id[3];
    int  m_rd;
    bit  armed = 0;
    int  vectors = 0, miscompares = 0, cycles = 0;
    string cur_req = "R1";

    function automatic bit in_class(int k, bit s, bit d, bit a);
        if (k == 0) return s && !d;
        if (k == 1) return d;
        return a && !s && !d;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (por_rst) begin
            foreach (m_dis[k]) begin m_dis[k] = 0; m_val[k] = 0; m_id[k] = 0; end
            m_rd = 0;
            armed = 1;
        end else begin
            int roff;
            roff = int'(reg_off) - 128;
            if (warm_rst || !rd_en) m_rd = 0;
            else if (roff >= 0 && roff < 3) m_rd = m_dis[roff]*128 + m_val[roff]*64 + m_id[roff];
            else m_rd = 0;
            for (int k = 0; k < 3; k++) begin
                int old_dis;
                old_dis = m_dis[k];
                if (wr_en && reg_off == 8'(128 + k)) begin
                    m_dis[k] = wr_data[7];
                    if (wr_data[6]) begin m_val[k] = 0; m_id[k] = 0; end
                end
                if (ret_vld && in_class(k, ret_sec, ret_ded, ret_ade) && old_dis == 0 && m_val[k] == 0) begin
                    m_val[k] = 1;
                    m_id[k]  = int'(ret_id);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            vectors++;
            if (int'(rd_data) != m_rd) begin
                miscompares++;
                $display("FAIL %s rd_data actual=%02h expected=%02h", cur_req, rd_data, m_rd[7:0]);
            end
            for (int k = 0; k < 3; k++) begin
                if (int'(hold_vld[k]) != m_val[k] || int'(hold_id[k]) != m_id[k]) begin
                    miscompares++;
                    $display("FAIL %s hold[%0d] actual=%0b/%02h expected=%0d/%02h",
                             cur_req, k, hold_vld[k], hold_id[k], m_val[k], m_id[k]);
                end
            end
        end
    end

    task automatic idle();
        ret_vld = 0; wr_en = 0; rd_en = 0; warm_rst = 0; por_rst = 0;
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic retire(input bit s, input bit d, input bit a, input logic [5:0] id);
        idle(); ret_vld = 1; ret_sec = s; ret_ded = d; ret_ade = a; ret_id = id;
        step(); idle();
    endtask

    task automatic wr(input logic [7:0] off, input logic [7:0] dat);
        idle(); wr_en = 1; reg_off = off; wr_data = dat; step(); idle();
    endtask

    task automatic rd_expect(input logic [7:0] off, input logic [7:0] exp, input string tag);
        idle(); rd_en = 1; reg_off = off; step(); idle();
        vectors++;
        if (rd_data !== exp) begin
            miscompares++;
            $display("FAIL %s read %02h actual=%02h expected=%02h", tag, off, rd_data, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) if (cycles > 100000) begin
        miscompares++;
        $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
        finish_run();
    end

    initial begin
        step(); step(); step();
        cur_req = "R1"; idle(); step();
        rd_expect(8'h80, 8'h00, "R1");
        cur_req = "R2";
        rd_expect(8'h83, 8'h00, "R2");
        rd_expect(8'h7F, 8'h00, "R2");
        cur_req = "R4"; retire(1, 0, 0, 6'd5);
        rd_expect(8'h80, 8'h45, "R4");
        cur_req = "R3"; retire(1, 1, 1, 6'd9);
        rd_expect(8'h81, 8'h49, "R3");
        rd_expect(8'h80, 8'h45, "R3");
        cur_req = "R5"; retire(1, 0, 1, 6'd3); retire(0, 0, 0, 6'd4);
        rd_expect(8'h82, 8'h00, "R5");
        retire(0, 0, 1, 6'd12);
        rd_expect(8'h82, 8'h4C, "R5");
        cur_req = "R6"; retire(1, 0, 0, 6'd7); retire(0, 1, 0, 6'd8);
        rd_expect(8'h80, 8'h45, "R6");
        cur_req = "R8"; wr(8'h80, 8'h3F);
        rd_expect(8'h80, 8'h45, "R8");
        cur_req = "R9"; wr(8'h80, 8'h40);
        rd_expect(8'h80, 8'h00, "R9");
        cur_req = "R10";
        idle(); wr_en = 1; reg_off = 8'h81; wr_data = 8'h40;
        ret_vld = 1; ret_sec = 0; ret_ded = 1; ret_ade = 0; ret_id = 6'd33;
        step(); idle();
        rd_expect(8'h81, 8'h61, "R10");
        cur_req = "R7"; wr(8'h80, 8'h80); retire(1, 0, 0, 6'd21);
        rd_expect(8'h80, 8'h80, "R7");
        wr(8'h80, 8'h00); retire(1, 0, 0, 6'd22);
        rd_expect(8'h80, 8'h56, "R7");
        cur_req = "R11"; idle(); warm_rst = 1; rd_en = 1; reg_off = 8'h81; step(); idle();
        rd_expect(8'h82, 8'h4C, "R11");
        cur_req = "R1"; idle(); por_rst = 1; step(); idle();
        rd_expect(8'h82, 8'h00, "R1");
        cur_req = "R6";
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            ret_vld = r[0]; ret_sec = r[1]; ret_ded = r[2] & r[3]; ret_ade = r[4];
            ret_id = r[10:5];
            wr_en = (r[13:11] == 0); rd_en = r[14];
            reg_off = 8'h7F + 8'(r[16:15]);
            wr_data = {r[17] & r[18], r[19], r[25:20]};
            warm_rst = (r[30:26] == 0);
            por_rst = (n % 997 == 996);
            step();
        end
        idle(); step(); step();
        finish_run();
    end
endmodule